// File: doc/BRIEF.md
# Four-Channel Cycle-Stealing DMA Controller

This block copies data for the CPU. It moves data from a peripheral to memory, or from one memory region to another. It shares one system bus with the CPU and never holds that bus for a burst. Each transfer steals exactly two bus accesses: a read at the channel's source address and then a write at its destination address. After every write the block drops its bus request for at least one cycle, so the CPU gets the bus between transfers.

There are four channels. Each channel has three request inputs: a level-sensitive primary hardware request, a level-sensitive secondary hardware request, and a software request that the CPU posts through the register interface. A control bit picks which of the two hardware requests the channel listens to. At integration the request pins are wired in a fixed way:
- Channel 0 uses a serial-port receive request as its secondary source.
- Channel 1 uses a serial-port transmit request as its primary source.
- Channel 2 uses an audio-port receive request as primary and a codec-converter read request as secondary.
- Channel 3 uses an audio-port transmit request as primary and a codec-converter write request as secondary.

Unused pins are tied low. Each channel has a transfer count. When the count runs out, the channel disables itself, sets a done flag and can raise an interrupt.

Top module: `dma4_ctrl`

## Requirements
- R1: While reset is active and after it is released, `bus_req` and all `irq` bits are low, and every channel register reads zero.
- R2: The register address is `cfg_addr[3:2]` for the channel and `cfg_addr[1:0]` for the register, with 0 = source address, 1 = destination address, 2 = count, 3 = control. The control bits are:
  - bit 0: enable
  - bit 1: hardware select (0 = primary, 1 = secondary)
  - bit 2: source increment
  - bit 3: destination increment
  - bit 4: word size (1 = 16-bit, 0 = byte)
  - bit 5: interrupt enable
  - bit 6: software request (writing 1 posts it, it reads back as pending)
  - bit 7: done (read-only, cleared by any control write)
- R3: A channel starts a transfer only when all of these hold: it is enabled, its count is nonzero, and either a software request is pending or the selected hardware request is high. The unselected hardware request has no effect.
- R4: When several channels are eligible, the lowest-numbered channel is served first. Only one channel transfers at a time.
- R5: A transfer is a read access (`bus_wr`=0) at the source address followed by a write access (`bus_wr`=1) at the destination address. While `bus_gnt` is low, `bus_req`, `bus_addr` and `bus_wr` are held. The cycle after a granted write has `bus_req` low.
- R6: In word mode the written data equals the data read and `bus_word` is 1. In byte mode the written data is the low byte of the read data, zero-extended, and `bus_word` is 0.
- R7: After each transfer, the source address and the destination address each advance by 2 (word) or 1 (byte) if their own increment bit is set, and otherwise stay unchanged.
- R8: The count drops by one per transfer. The transfer that brings it to zero also clears enable and sets done. `irq[ch]` is high exactly when done and interrupt enable are both set.
- R9: A hardware request is sampled anew before each transfer. A request held high for a single idle cycle yields exactly one transfer.
- R10: A software request is withdrawn when its transfer starts. One write of the software request bit yields exactly one transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register address {channel, register} |
| cfg_wdata | input | 16 | Register write data |
| cfg_rdata | output | 16 | Register read data for `cfg_addr` |
| pri_req | input | 4 | Primary hardware request per channel |
| sec_req | input | 4 | Secondary hardware request per channel |
| bus_req | output | 1 | Bus access request |
| bus_gnt | input | 1 | Bus grant; the access completes on a clock edge where it is high |
| bus_wr | output | 1 | 1 = write access, 0 = read access |
| bus_word | output | 1 | 1 = 16-bit access, 0 = byte access |
| bus_addr | output | 16 | Access address |
| bus_wdata | output | 16 | Write data |
| bus_rdata | input | 16 | Read data, taken when a read is granted |
| irq | output | 4 | Per-channel interrupt |

## Verification
Two pairs of events can fall in the same cycle.

The first pair is channel 0 and channel 3 becoming eligible on the same clock edge. The bench raises channel 0's secondary request and channel 3's primary request together, while the grant is held low. The scoreboard then requires channel 0's read and write before any access by channel 3.

The second pair is a channel's final transfer and the release of the bus. The bench checks that the cycle after every granted write has the request low. Once the count reaches zero, the bench reads back the count, the addresses and the control register, and checks the interrupt pins.

// File: rtl/dma4_pkg.sv
package dma4_pkg;
  // control register bit positions
  localparam int CB_EN   = 0;
  localparam int CB_SEL  = 1;
  localparam int CB_SINC = 2;
  localparam int CB_DINC = 3;
  localparam int CB_WORD = 4;
  localparam int CB_IEN  = 5;
  localparam int CB_SWR  = 6;
  localparam int CB_DONE = 7;
  localparam int CTRL_W  = 8;

  // register selectors
  localparam logic [1:0] RS_SRC  = 2'd0;
  localparam logic [1:0] RS_DST  = 2'd1;
  localparam logic [1:0] RS_CNT  = 2'd2;
  localparam logic [1:0] RS_CTRL = 2'd3;

  typedef enum logic [1:0] {ENG_IDLE, ENG_RD, ENG_WR} eng_state_t;
endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma4_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hit,
  input  logic [1:0]        wr_reg,
  input  logic [DW-1:0]     wr_data,
  input  logic              hw_pri,
  input  logic              hw_sec,
  input  logic              start,
  input  logic              finish,
  output logic [AW-1:0]     src_addr,
  output logic [AW-1:0]     dst_addr,
  output logic [DW-1:0]     cnt,
  output logic [CTRL_W-1:0] ctrl,
  output logic              ready,
  output logic              irq
);
  logic [AW-1:0] src_q, src_n, dst_q, dst_n;
  logic [DW-1:0] cnt_q, cnt_n;
  logic en_q, en_n, sel_q, sel_n, sinc_q, sinc_n, dinc_q, dinc_n;
  logic word_q, word_n, ien_q, ien_n, swr_q, swr_n, done_q, done_n;
  logic [AW-1:0] step;

  assign step = word_q ? AW'(2) : AW'(1);

  always_comb begin
    src_n = src_q;   dst_n = dst_q;   cnt_n = cnt_q;
    en_n = en_q;     sel_n = sel_q;   sinc_n = sinc_q; dinc_n = dinc_q;
    word_n = word_q; ien_n = ien_q;   swr_n = swr_q;   done_n = done_q;
    if (start) swr_n = 1'b0;
    if (wr_hit) begin
      unique case (wr_reg)
        RS_SRC: src_n = wr_data[AW-1:0];
        RS_DST: dst_n = wr_data[AW-1:0];
        RS_CNT: cnt_n = wr_data;
        default: begin
          en_n   = wr_data[CB_EN];
          sel_n  = wr_data[CB_SEL];
          sinc_n = wr_data[CB_SINC];
          dinc_n = wr_data[CB_DINC];
          word_n = wr_data[CB_WORD];
          ien_n  = wr_data[CB_IEN];
          swr_n  = swr_n | wr_data[CB_SWR];
          done_n = 1'b0;
        end
      endcase
    end
    if (finish) begin
      if (sinc_q) src_n = src_q + step;
      if (dinc_q) dst_n = dst_q + step;
      cnt_n = cnt_q - DW'(1);
      if (cnt_q == DW'(1)) begin
        en_n   = 1'b0;
        done_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= '0; dst_q <= '0; cnt_q <= '0;
      en_q <= 1'b0; sel_q <= 1'b0; sinc_q <= 1'b0; dinc_q <= 1'b0;
      word_q <= 1'b0; ien_q <= 1'b0; swr_q <= 1'b0; done_q <= 1'b0;
    end else begin
      src_q <= src_n; dst_q <= dst_n; cnt_q <= cnt_n;
      en_q <= en_n; sel_q <= sel_n; sinc_q <= sinc_n; dinc_q <= dinc_n;
      word_q <= word_n; ien_q <= ien_n; swr_q <= swr_n; done_q <= done_n;
    end
  end

  assign src_addr = src_q;
  assign dst_addr = dst_q;
  assign cnt      = cnt_q;
  assign ctrl     = {done_q, swr_q, ien_q, word_q, dinc_q, sinc_q, sel_q, en_q};
  assign ready    = en_q && (cnt_q != '0) && (swr_q || (sel_q ? hw_sec : hw_pri));
  assign irq      = done_q & ien_q;

  // R8
  cnt_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (finish && !wr_hit) |=> (cnt_q == $past(cnt_q) - DW'(1)));
  // R8
  last_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (finish && !wr_hit && cnt_q == DW'(1)) |=> (done_q && !en_q));
  // R10
  swr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !wr_hit) |=> !swr_q);
  // R3
  start_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (en_q && cnt_q != '0));
endmodule

// File: rtl/dma_prio_arb.sv
module dma_prio_arb #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt,
  output logic         valid
);
  always_comb begin
    gnt = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) gnt = N'(1) << i;
    end
  end
  assign valid = |req;

  // R4
  arb_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt) && ((|req) == (|gnt)));
  // R4
  arb_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|req) |-> (((gnt - N'(1)) & req) == '0 && (gnt & req) != '0));
endmodule

// File: rtl/dma_engine.sv
module dma_engine
  import dma4_pkg::*;
#(
  parameter int N  = 4,
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  grant,
  input  logic          grant_valid,
  input  logic [AW-1:0] cur_src,
  input  logic [AW-1:0] cur_dst,
  input  logic          cur_word,
  output logic [N-1:0]  cur_oh,
  output logic [N-1:0]  start,
  output logic [N-1:0]  finish,
  output logic          bus_req,
  input  logic          bus_gnt,
  output logic          bus_wr,
  output logic          bus_word,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata
);
  eng_state_t st_q, st_n;
  logic [N-1:0]  cur_q, cur_n;
  logic [DW-1:0] data_q, data_n;
  logic          data_ld;

  always_comb begin
    st_n = st_q; cur_n = cur_q; data_n = data_q; data_ld = 1'b0;
    start = '0; finish = '0;
    bus_req = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_word = 1'b0;
    unique case (st_q)
      ENG_IDLE: begin
        if (grant_valid) begin
          start = grant;
          cur_n = grant;
          st_n  = ENG_RD;
        end
      end
      ENG_RD: begin
        bus_req  = 1'b1;
        bus_addr = cur_src;
        bus_word = cur_word;
        if (bus_gnt) begin
          data_ld = 1'b1;
          data_n  = cur_word ? bus_rdata : {{(DW-8){1'b0}}, bus_rdata[7:0]};
          st_n    = ENG_WR;
        end
      end
      default: begin
        bus_req  = 1'b1;
        bus_wr   = 1'b1;
        bus_addr = cur_dst;
        bus_word = cur_word;
        if (bus_gnt) begin
          finish = cur_q;
          st_n   = ENG_IDLE;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ENG_IDLE;
      cur_q  <= '0;
      data_q <= '0;
    end else begin
      st_q  <= st_n;
      cur_q <= cur_n;
      if (data_ld) data_q <= data_n;
    end
  end

  assign cur_oh    = cur_q;
  assign bus_wdata = data_q;

  // R5
  bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_gnt) |=> (bus_req && $stable(bus_addr) && $stable(bus_wr)));
  // R5
  bus_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_gnt && bus_wr) |=> !bus_req);
  // R5
  rd_then_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_gnt && !bus_wr) |=> (bus_req && bus_wr));
endmodule

// File: rtl/dma4_ctrl.sv
module dma4_ctrl
  import dma4_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 16,
  parameter int DW  = 16,
  localparam int CHW = $clog2(NCH),
  localparam int CAW = CHW + 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_wr,
  input  logic [CAW-1:0] cfg_addr,
  input  logic [DW-1:0]  cfg_wdata,
  output logic [DW-1:0]  cfg_rdata,
  input  logic [NCH-1:0] pri_req,
  input  logic [NCH-1:0] sec_req,
  output logic           bus_req,
  input  logic           bus_gnt,
  output logic           bus_wr,
  output logic           bus_word,
  output logic [AW-1:0]  bus_addr,
  output logic [DW-1:0]  bus_wdata,
  input  logic [DW-1:0]  bus_rdata,
  output logic [NCH-1:0] irq
);
  logic [1:0] rst_sync_q;
  logic       rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i = rst_sync_q[1];

  logic [AW-1:0]     src_a  [NCH];
  logic [AW-1:0]     dst_a  [NCH];
  logic [DW-1:0]     cnt_a  [NCH];
  logic [CTRL_W-1:0] ctrl_a [NCH];
  logic [NCH-1:0] ready, grant, start, finish, cur_oh;
  logic           grant_valid;
  logic [AW-1:0]  cur_src, cur_dst;
  logic           cur_word;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    dma_chan_regs #(.AW(AW), .DW(DW)) u_regs (
      .clk      (clk),
      .rst_n    (rst_i),
      .wr_hit   (cfg_wr && (cfg_addr[CAW-1:2] == CHW'(g))),
      .wr_reg   (cfg_addr[1:0]),
      .wr_data  (cfg_wdata),
      .hw_pri   (pri_req[g]),
      .hw_sec   (sec_req[g]),
      .start    (start[g]),
      .finish   (finish[g]),
      .src_addr (src_a[g]),
      .dst_addr (dst_a[g]),
      .cnt      (cnt_a[g]),
      .ctrl     (ctrl_a[g]),
      .ready    (ready[g]),
      .irq      (irq[g])
    );
  end

  dma_prio_arb #(.N(NCH)) u_arb (
    .clk   (clk),
    .rst_n (rst_i),
    .req   (ready),
    .gnt   (grant),
    .valid (grant_valid)
  );

  always_comb begin
    cur_src  = '0;
    cur_dst  = '0;
    cur_word = 1'b0;
    for (int i = 0; i < NCH; i++) begin
      cur_src  = cur_src | ({AW{cur_oh[i]}} & src_a[i]);
      cur_dst  = cur_dst | ({AW{cur_oh[i]}} & dst_a[i]);
      cur_word = cur_word | (cur_oh[i] & ctrl_a[i][CB_WORD]);
    end
  end

  dma_engine #(.N(NCH), .AW(AW), .DW(DW)) u_eng (
    .clk         (clk),
    .rst_n       (rst_i),
    .grant       (grant),
    .grant_valid (grant_valid),
    .cur_src     (cur_src),
    .cur_dst     (cur_dst),
    .cur_word    (cur_word),
    .cur_oh      (cur_oh),
    .start       (start),
    .finish      (finish),
    .bus_req     (bus_req),
    .bus_gnt     (bus_gnt),
    .bus_wr      (bus_wr),
    .bus_word    (bus_word),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata)
  );

  always_comb begin
    unique case (cfg_addr[1:0])
      RS_SRC:  cfg_rdata = DW'(src_a[cfg_addr[CAW-1:2]]);
      RS_DST:  cfg_rdata = DW'(dst_a[cfg_addr[CAW-1:2]]);
      RS_CNT:  cfg_rdata = cnt_a[cfg_addr[CAW-1:2]];
      default: cfg_rdata = DW'(ctrl_a[cfg_addr[CAW-1:2]]);
    endcase
  end

  // R4
  one_active_chk: assert property (@(posedge clk) disable iff (!rst_i)
    $onehot0(start) && $onehot0(finish));
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_i |-> (!bus_req && irq == '0));
endmodule

// File: tb/dma4_ctrl_test.sv
module dma4_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_wr;
  logic [3:0]  cfg_addr;
  logic [15:0] cfg_wdata, cfg_rdata;
  logic [3:0]  pri_req, sec_req;
  logic        bus_req, bus_gnt, bus_wr, bus_word;
  logic [15:0] bus_addr, bus_wdata, bus_rdata;
  logic [3:0]  irq;

  int checks = 0;
  int errors = 0;

  typedef struct {
    bit          wr;
    bit          word;
    logic [15:0] addr;
    logic [15:0] data;
  } acc_t;
  acc_t sb[$];

  localparam logic [15:0] C_EN = 16'h01, C_SEL = 16'h02, C_SINC = 16'h04,
                          C_DINC = 16'h08, C_WORD = 16'h10, C_IEN = 16'h20,
                          C_SWR = 16'h40, C_DONE = 16'h80;

  always #10 clk = ~clk;

  dma4_ctrl uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .pri_req(pri_req),
    .sec_req(sec_req), .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_wr(bus_wr),
    .bus_word(bus_word), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  function automatic logic [15:0] mem_val(input logic [15:0] a);
    return a ^ 16'hC35A;
  endfunction
  assign bus_rdata = mem_val(bus_addr);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic expect_xfer(input logic [15:0] s, input logic [15:0] d, input bit word);
    acc_t r, w;
    r.wr = 1'b0; r.word = word; r.addr = s; r.data = '0;
    w.wr = 1'b1; w.word = word; w.addr = d;
    w.data = word ? mem_val(s) : {8'h00, mem_val(s)[7:0]};
    sb.push_back(r);
    sb.push_back(w);
  endtask

  // scoreboard monitor, sampling mid-cycle
  bit prev_wr_gnt = 1'b0;
  always @(negedge clk) begin
    if (prev_wr_gnt) begin
      checks++;
      if (bus_req) begin
        errors++;
        $display("FAIL R5: bus_req got 1 expected 0 after write");
      end
    end
    prev_wr_gnt = bus_req && bus_gnt && bus_wr;
    if (bus_req && bus_gnt) begin
      if (sb.size() == 0) begin
        checks++; errors++;
        $display("FAIL R3: unexpected access addr %h wr %0d expected none", bus_addr, bus_wr);
      end else begin
        acc_t e;
        e = sb.pop_front();
        chk("R4 R5 R7 addr", {15'd0, bus_wr, bus_addr}, {15'd0, e.wr, e.addr});
        chk("R6 size", {31'd0, bus_word}, {31'd0, e.word});
        if (e.wr) chk("R6 data", {16'd0, bus_wdata}, {16'd0, e.data});
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic cfg_write(input int ch, input int r, input logic [15:0] d);
    @(posedge clk); #2;
    cfg_wr = 1'b1; cfg_addr = {ch[1:0], r[1:0]}; cfg_wdata = d;
    @(posedge clk); #2;
    cfg_wr = 1'b0;
  endtask

  task automatic cfg_read(input int ch, input int r, output logic [15:0] d);
    cfg_addr = {ch[1:0], r[1:0]};
    #1;
    d = cfg_rdata;
  endtask

  task automatic wait_drain();
    for (int i = 0; i < 400 && sb.size() != 0; i++) cyc(1);
    cyc(3);
    chk("R4 pending accesses", sb.size(), 0);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: run got stuck expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] v;
    rst_n = 1'b0; cfg_wr = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    pri_req = '0; sec_req = '0; bus_gnt = 1'b1;
    cyc(4);
    chk("R1 bus_req in reset", {31'd0, bus_req}, 0);
    rst_n = 1'b1;
    cyc(4);
    chk("R1 bus_req", {31'd0, bus_req}, 0);
    chk("R1 irq", {28'd0, irq}, 0);
    cfg_read(0, 3, v); chk("R1 ctrl0", {16'd0, v}, 0);
    cfg_read(3, 2, v); chk("R1 count3", {16'd0, v}, 0);

    // software-triggered word copy on channel 2: R2 R6 R7 R8 R10
    cfg_write(2, 0, 16'h0100);
    cfg_write(2, 1, 16'h0200);
    cfg_write(2, 2, 16'd3);
    for (int k = 0; k < 3; k++) begin
      expect_xfer(16'h0100 + 16'(2 * k), 16'h0200 + 16'(2 * k), 1'b1);
      cfg_write(2, 3, C_EN | C_SINC | C_DINC | C_WORD | C_IEN | C_SWR);
      wait_drain();
      cfg_read(2, 2, v); chk("R10 one transfer per sw write", {16'd0, v}, 32'(2 - k));
    end
    cfg_read(2, 3, v);
    chk("R8 R2 ctrl after last", {16'd0, v}, {16'd0, C_DONE | C_IEN | C_WORD | C_DINC | C_SINC});
    cfg_read(2, 0, v); chk("R7 src advanced", {16'd0, v}, 32'h0106);
    cfg_read(2, 1, v); chk("R7 dst advanced", {16'd0, v}, 32'h0206);
    chk("R8 irq raised", {28'd0, irq}, 32'h4);
    cfg_write(2, 3, 16'h0000);
    cyc(1);
    chk("R8 irq cleared by ctrl write", {28'd0, irq}, 0);

    // channel 1 byte mode, primary selected: R3 R6 R7
    cfg_write(1, 0, 16'h0031);
    cfg_write(1, 1, 16'h0400);
    cfg_write(1, 2, 16'd4);
    cfg_write(1, 3, C_EN | C_DINC);
    sec_req[1] = 1'b1;
    cyc(10);
    cfg_read(1, 2, v); chk("R3 unselected request ignored", {16'd0, v}, 4);
    sec_req[1] = 1'b0;
    for (int k = 0; k < 4; k++) expect_xfer(16'h0031, 16'h0400 + 16'(k), 1'b0);
    pri_req[1] = 1'b1;
    wait_drain();
    pri_req[1] = 1'b0;
    cfg_read(1, 3, v); chk("R8 ctrl ch1 done", {16'd0, v}, {16'd0, C_DONE | C_DINC});
    cfg_read(1, 0, v); chk("R7 src fixed", {16'd0, v}, 32'h0031);
    cfg_read(1, 1, v); chk("R7 dst byte step", {16'd0, v}, 32'h0404);
    chk("R8 no irq without enable", {28'd0, irq}, 0);

    // one-cycle hardware pulse: R9
    cfg_write(1, 1, 16'h0500);
    cfg_write(1, 2, 16'd3);
    cfg_write(1, 3, C_EN | C_DINC);
    expect_xfer(16'h0031, 16'h0500, 1'b0);
    cyc(1);
    pri_req[1] = 1'b1;
    cyc(1);
    pri_req[1] = 1'b0;
    wait_drain();
    cyc(6);
    cfg_read(1, 2, v); chk("R9 single transfer per pulse", {16'd0, v}, 2);
    cfg_write(1, 3, 16'h0000);

    // simultaneous channels with grant withheld: R4 R5
    cfg_write(0, 0, 16'h0600); cfg_write(0, 1, 16'h0900); cfg_write(0, 2, 16'd1);
    cfg_write(0, 3, C_EN | C_SEL | C_WORD | C_SINC);
    cfg_write(3, 0, 16'h0700); cfg_write(3, 1, 16'h0800); cfg_write(3, 2, 16'd1);
    cfg_write(3, 3, C_EN | C_WORD);
    expect_xfer(16'h0600, 16'h0900, 1'b1);
    expect_xfer(16'h0700, 16'h0800, 1'b1);
    bus_gnt = 1'b0;
    sec_req[0] = 1'b1;
    pri_req[3] = 1'b1;
    cyc(4);
    chk("R5 request held", {31'd0, bus_req}, 1);
    chk("R4 R5 lowest channel address held", {16'd0, bus_addr}, 32'h0600);
    chk("R5 read first", {31'd0, bus_wr}, 0);
    bus_gnt = 1'b1;
    wait_drain();
    sec_req[0] = 1'b0;
    pri_req[3] = 1'b0;
    cfg_read(0, 3, v); chk("R8 ch0 done", {16'd0, v}, {16'd0, C_DONE | C_WORD | C_SINC | C_SEL});
    cfg_read(3, 3, v); chk("R8 ch3 done", {16'd0, v}, {16'd0, C_DONE | C_WORD});
    cfg_read(0, 0, v); chk("R7 ch0 src word step", {16'd0, v}, 32'h0602);
    chk("R8 irq off", {28'd0, irq}, 0);
    finish_run();
  end
endmodule